// File: doc/BRIEF.md
# BCD time and calendar counter

This block holds the time of day and the calendar date as packed BCD fields and advances them on a single-cycle tick enable. The tick comes from a reference clock running at 1 Hz or 100 Hz. The parameter `TICK_HZ` fixes the rate at build time. At 100 Hz a hundredths field counts first. At 1 Hz every tick adds one second and the hundredths field stays at 00. Software loads a time word and a calendar word directly. Each write is checked field by field. A write that fails the check is dropped, and a per-word valid flag records the result of the most recent write. Two stop bits freeze the time and calendar counters independently. A one-bit hour-mode register selects 24-hour or 12-hour counting; changing it converts the stored hour.

The time counter is updated in the same edge as the tick that advances it. A midnight carry hands over to the calendar through a small sequencer with three states:
- `ST_IDLE`: the calendar waits.
- `ST_CAL`: the calendar steps once, one clock after the carry.
- `ST_LIMIT`: entered when the carry would take the date past 31 December 2999. Both counters then hold.

The sequencer has these transitions:
- `ST_IDLE` to `ST_CAL`: a midnight carry while the calendar runs.
- `ST_CAL` to `ST_IDLE`: always, after one cycle.
- `ST_IDLE` to `ST_LIMIT`: a midnight carry from the last supported day.
- `ST_LIMIT` to `ST_IDLE`: a write of a valid time word or a valid calendar word.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the time word reads 0 (00:00:00.00). The calendar word reads 1900-01-01 with weekday 1. Both stop bits are 1, the hour mode is 0 (24-hour), and both valid flags and both change bits are 0.
- R2: The time word fields are: hundredths in bits 7:0, seconds in bits 14:8, minutes in bits 22:16, hours in bits 29:24, PM in bit 30 and the change bit in bit 31. All fields count in BCD. With `TICK_HZ`=100 the hundredths go 00..99 and then carry into seconds. With `TICK_HZ`=1 the hundredths stay 00 and each tick adds one second.
- R3: In 24-hour mode, 23:59:59.99 plus one tick gives 00:00:00.00, and the calendar takes exactly one step one cycle later.
- R4: Hour mode 1 counts hours 01..12 with PM in bit 30. The hour goes 11 to 12 with PM toggling and 12 to 01. 11:59:59 PM rolls to 12 AM and steps the calendar. Switching modes converts the stored hour (13 h becomes 01 PM; 12 AM becomes 00 h). If a time write and an hour-mode write arrive in the same cycle, the hour-mode write is ignored.
- R5: Stop bit 0 (value 1) freezes the time word and stop bit 1 freezes the calendar word. A midnight carry while only the calendar is stopped wraps the time and leaves the calendar unchanged.
- R6: The calendar word fields are: weekday 1..7 in bits 2:0, month in bits 7:3, date in bits 13:8, year in bits 23:16, century in bits 29:24 and the change bit in bit 31. A step past the last day of a month gives date 01. February has 29 days when the year is divisible by 4, except in century years whose century is not divisible by 4.
- R7: A step from 31 December gives 1 January. Year 99 rolls to 00 and increments the century.
- R8: The weekday advances on every calendar step and wraps from 7 to 1.
- R9: A time write loads only if every digit is BCD and the values are in range: seconds and minutes 00..59, hours 00..23 with PM 0 in 24-hour mode or 01..12 in 12-hour mode, and hundredths 00 at 1 Hz. The time valid flag takes the result of the check. A rejected write leaves the time word unchanged.
- R10: A calendar write loads only if every digit is BCD and the values are in range: weekday 1..7, month 01..12, date 01 up to that month's length in the written year, century 19..29. The calendar valid flag takes the result of the check. A rejected write leaves the calendar word unchanged.
- R11: A midnight carry from 2999-12-31 is refused. The time stays at its last value, and both words hold through further ticks until a valid time or calendar write is made.
- R12: Bit 31 of each word reads 1 only in the cycle after that word advanced by counting. A written bit 31 is ignored.
- R13: A time write in the same cycle as a tick loads the written value unchanged, and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick enable, one cycle wide |
| tm_wr_en | input | 1 | Time word write strobe |
| tm_wr_data | input | 32 | Time word to load |
| cal_wr_en | input | 1 | Calendar word write strobe |
| cal_wr_data | input | 32 | Calendar word to load |
| ctl_wr_en | input | 1 | Stop-bit write strobe |
| ctl_wr_data | input | 2 | Stop bits: bit 0 time, bit 1 calendar |
| hm_wr_en | input | 1 | Hour-mode write strobe |
| hm_wr_data | input | 1 | Hour mode: 0 is 24-hour, 1 is 12-hour |
| time_word | output | 32 | Current time word |
| cal_word | output | 32 | Current calendar word |
| ctl_q | output | 2 | Current stop bits |
| hour_mode | output | 1 | Current hour mode |
| time_ok | output | 1 | Last time write was valid |
| cal_ok | output | 1 | Last calendar write was valid |

## Verification
The bench steps midnight through every month of six years. The years cover the plain leap year, the non-leap century year (1900, 2100), the leap century year (2000) and the century carry (1999). A wrong leap rule or month-length table would either roll a day early or accept an impossible 29 February.

It sweeps every raw code of the seconds and hours fields in both hour modes. A loose range check would load a value such as 0x60 or 0x24 that the counters could never leave cleanly.

The 12-hour noon and midnight transitions are checked; a design that got them wrong would carry a day at noon or show hour 00. The bench also checks the 2999 limit, where a wrong design would wrap the century to 30. Finally, it checks a write landing on a tick, where a wrong design would load the value one count ahead.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CAL   = 2'd1,
        ST_LIMIT = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic       pm;
        logic [5:0] hr;
        logic [6:0] mn;
        logic [6:0] sc;
        logic [7:0] hs;
    } tod_t;

    typedef struct packed {
        logic [5:0] cent;
        logic [7:0] yr;
        logic [5:0] date;
        logic [4:0] mon;
        logic [2:0] wday;
    } cal_t;

    localparam logic [5:0] CENT_LO = 6'h19;
    localparam logic [5:0] CENT_HI = 6'h29;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic digit_ok(input logic [3:0] d);
        return d <= 4'd9;
    endfunction

    function automatic logic [6:0] bcd_bin(input logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    function automatic logic leap_of(input logic [5:0] cent, input logic [7:0] yr);
        logic [6:0] cb;
        logic [6:0] yb;
        cb = bcd_bin({2'b00, cent});
        yb = bcd_bin(yr);
        if (yr == 8'h00) return cb[1:0] == 2'd0;
        return yb[1:0] == 2'd0;
    endfunction

    function automatic logic [5:0] month_len(input logic [4:0] mon, input logic leap);
        case (mon)
            5'h02:                      return leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

    function automatic logic [4:0] hr_bin(input logic [5:0] h);
        return 5'(h[5:4]) * 5'd10 + 5'(h[3:0]);
    endfunction

    function automatic logic [5:0] hr_bcd(input logic [4:0] b);
        if (b >= 5'd20) return {2'd2, 4'(b - 5'd20)};
        if (b >= 5'd10) return {2'd1, 4'(b - 5'd10)};
        return {2'd0, b[3:0]};
    endfunction

    // returns {pm, hour} in 12-hour form
    function automatic logic [6:0] hr_to12(input logic [5:0] h24);
        logic [4:0] b;
        b = hr_bin(h24);
        if (b == 5'd0)  return {1'b0, 6'h12};
        if (b < 5'd12)  return {1'b0, h24};
        if (b == 5'd12) return {1'b1, 6'h12};
        return {1'b1, hr_bcd(b - 5'd12)};
    endfunction

    function automatic logic [5:0] hr_to24(input logic pm, input logic [5:0] h12);
        logic [4:0] b;
        b = hr_bin(h12);
        if (b == 5'd12) return pm ? 6'h12 : 6'h00;
        return pm ? hr_bcd(b + 5'd12) : h12;
    endfunction

endpackage

// File: rtl/rtc_tod_step.sv
module rtc_tod_step
    import rtc_pkg::*;
#(
    parameter int TICK_HZ = 100
) (
    input  tod_t cur,
    input  logic mode12,
    output tod_t nxt,
    output logic day_wrap
);

    logic       sec_carry;
    logic [7:0] hs_next;
    logic       min_carry;
    logic       hr_carry;

    generate
        if (TICK_HZ == 100) begin : g_hund
            assign sec_carry = (cur.hs == 8'h99);
            assign hs_next   = sec_carry ? 8'h00 : bcd_inc(cur.hs);
        end else begin : g_whole
            assign sec_carry = 1'b1;
            assign hs_next   = 8'h00;
        end
    endgenerate

    always_comb begin
        nxt       = cur;
        nxt.hs    = hs_next;
        min_carry = 1'b0;
        hr_carry  = 1'b0;
        day_wrap  = 1'b0;
        if (sec_carry) begin
            if (cur.sc == 7'h59) begin
                nxt.sc    = 7'h00;
                min_carry = 1'b1;
            end else begin
                nxt.sc = 7'(bcd_inc({1'b0, cur.sc}));
            end
        end
        if (min_carry) begin
            if (cur.mn == 7'h59) begin
                nxt.mn   = 7'h00;
                hr_carry = 1'b1;
            end else begin
                nxt.mn = 7'(bcd_inc({1'b0, cur.mn}));
            end
        end
        if (hr_carry) begin
            if (mode12) begin
                if (cur.hr == 6'h12) begin
                    nxt.hr = 6'h01;
                end else if (cur.hr == 6'h11) begin
                    nxt.hr   = 6'h12;
                    nxt.pm   = ~cur.pm;
                    day_wrap = cur.pm;
                end else begin
                    nxt.hr = 6'(bcd_inc({2'b00, cur.hr}));
                end
            end else if (cur.hr == 6'h23) begin
                nxt.hr   = 6'h00;
                day_wrap = 1'b1;
            end else begin
                nxt.hr = 6'(bcd_inc({2'b00, cur.hr}));
            end
        end
    end

endmodule

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
    import rtc_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt,
    output logic at_limit
);

    logic [5:0] last_day;

    always_comb begin
        last_day = month_len(cur.mon, leap_of(cur.cent, cur.yr));
        at_limit = (cur.cent == CENT_HI) && (cur.yr == 8'h99) &&
                   (cur.mon == 5'h12) && (cur.date == 6'h31);
        nxt      = cur;
        nxt.wday = (cur.wday == 3'd7) ? 3'd1 : cur.wday + 3'd1;
        if (cur.date >= last_day) begin
            nxt.date = 6'h01;
            if (cur.mon == 5'h12) begin
                nxt.mon = 5'h01;
                if (cur.yr == 8'h99) begin
                    nxt.yr   = 8'h00;
                    nxt.cent = 6'(bcd_inc({2'b00, cur.cent}));
                end else begin
                    nxt.yr = bcd_inc(cur.yr);
                end
            end else begin
                nxt.mon = 5'(bcd_inc({3'b000, cur.mon}));
            end
        end else begin
            nxt.date = 6'(bcd_inc({2'b00, cur.date}));
        end
    end

endmodule

// File: rtl/rtc_word_check.sv
module rtc_word_check
    import rtc_pkg::*;
#(
    parameter int TICK_HZ = 100
) (
    input  tod_t tw,
    input  cal_t cw,
    input  logic mode12,
    output logic tod_ok,
    output logic cal_ok
);

    logic hs_ok, sc_ok, mn_ok, hr_ok;
    logic wd_ok, mon_ok, date_ok, yr_ok, cent_ok;

    generate
        if (TICK_HZ == 100) begin : g_hund
            assign hs_ok = digit_ok(tw.hs[7:4]) && digit_ok(tw.hs[3:0]);
        end else begin : g_whole
            assign hs_ok = (tw.hs == 8'h00);
        end
    endgenerate

    always_comb begin
        sc_ok = (tw.sc[6:4] <= 3'd5) && digit_ok(tw.sc[3:0]);
        mn_ok = (tw.mn[6:4] <= 3'd5) && digit_ok(tw.mn[3:0]);
        if (mode12)
            hr_ok = digit_ok(tw.hr[3:0]) && (tw.hr != 6'h00) && (tw.hr <= 6'h12);
        else
            hr_ok = digit_ok(tw.hr[3:0]) && (tw.hr <= 6'h23) && !tw.pm;
        tod_ok = hs_ok && sc_ok && mn_ok && hr_ok;

        wd_ok   = (cw.wday != 3'd0);
        mon_ok  = digit_ok(cw.mon[3:0]) && (cw.mon != 5'h00) && (cw.mon <= 5'h12);
        yr_ok   = digit_ok(cw.yr[7:4]) && digit_ok(cw.yr[3:0]);
        cent_ok = digit_ok(cw.cent[3:0]) && (cw.cent >= CENT_LO) && (cw.cent <= CENT_HI);
        date_ok = digit_ok(cw.date[3:0]) && (cw.date != 6'h00) &&
                  (cw.date <= month_len(cw.mon, leap_of(cw.cent, cw.yr)));
        cal_ok  = wd_ok && mon_ok && yr_ok && cent_ok && date_ok;
    end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
#(
    parameter int TICK_HZ = 100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        tm_wr_en,
    input  logic [31:0] tm_wr_data,
    input  logic        cal_wr_en,
    input  logic [31:0] cal_wr_data,
    input  logic        ctl_wr_en,
    input  logic [1:0]  ctl_wr_data,
    input  logic        hm_wr_en,
    input  logic        hm_wr_data,
    output logic [31:0] time_word,
    output logic [31:0] cal_word,
    output logic [1:0]  ctl_q,
    output logic        hour_mode,
    output logic        time_ok,
    output logic        cal_ok
);

    localparam tod_t TOD_RST = '0;
    localparam cal_t CAL_RST = '{cent: CENT_LO, yr: 8'h00, date: 6'h01, mon: 5'h01, wday: 3'd1};

    seq_state_t state_q, state_d;
    tod_t       tod_q, tod_nxt, wr_tod;
    cal_t       cal_q, cal_nxt, wr_cal;
    logic       day_wrap, at_limit;
    logic       wr_tod_ok, wr_cal_ok;
    logic       tchg_q, cchg_q;
    logic       stop_t, stop_c;
    logic       hm_take, tod_tick;
    logic       tod_go, cal_go;
    logic       unused_wr;

    assign wr_tod = {tm_wr_data[30], tm_wr_data[29:24], tm_wr_data[22:16],
                     tm_wr_data[14:8], tm_wr_data[7:0]};
    assign wr_cal = {cal_wr_data[29:24], cal_wr_data[23:16], cal_wr_data[13:8],
                     cal_wr_data[7:3], cal_wr_data[2:0]};
    assign unused_wr = ^{tm_wr_data[31], tm_wr_data[23], tm_wr_data[15],
                         cal_wr_data[31:30], cal_wr_data[15:14]};

    rtc_tod_step #(.TICK_HZ(TICK_HZ)) u_tod (
        .cur      (tod_q),
        .mode12   (hour_mode),
        .nxt      (tod_nxt),
        .day_wrap (day_wrap)
    );

    rtc_cal_step u_cal (
        .cur      (cal_q),
        .nxt      (cal_nxt),
        .at_limit (at_limit)
    );

    rtc_word_check #(.TICK_HZ(TICK_HZ)) u_chk (
        .tw     (wr_tod),
        .cw     (wr_cal),
        .mode12 (hour_mode),
        .tod_ok (wr_tod_ok),
        .cal_ok (wr_cal_ok)
    );

    assign stop_t   = ctl_q[0];
    assign stop_c   = ctl_q[1];
    assign hm_take  = hm_wr_en && !tm_wr_en && (hm_wr_data != hour_mode);
    assign tod_tick = tick && !stop_t && !tm_wr_en && !hm_take;

    // sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and step decisions
    always_comb begin
        state_d = state_q;
        tod_go  = 1'b0;
        cal_go  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (tod_tick && day_wrap && !stop_c && !cal_wr_en) begin
                    if (at_limit) begin
                        state_d = ST_LIMIT;
                    end else begin
                        state_d = ST_CAL;
                        tod_go  = 1'b1;
                    end
                end else begin
                    tod_go = tod_tick;
                end
            end
            ST_CAL: begin
                tod_go  = tod_tick;
                cal_go  = !cal_wr_en && !stop_c;
                state_d = ST_IDLE;
            end
            ST_LIMIT: begin
                if ((tm_wr_en && wr_tod_ok) || (cal_wr_en && wr_cal_ok))
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered words, flags and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tod_q     <= TOD_RST;
            cal_q     <= CAL_RST;
            tchg_q    <= 1'b0;
            cchg_q    <= 1'b0;
            ctl_q     <= 2'b11;
            hour_mode <= 1'b0;
            time_ok   <= 1'b0;
            cal_ok    <= 1'b0;
        end else begin
            if (tm_wr_en) begin
                if (wr_tod_ok) tod_q <= wr_tod;
                time_ok <= wr_tod_ok;
            end else if (hm_take) begin
                hour_mode <= hm_wr_data;
                if (hm_wr_data) begin
                    {tod_q.pm, tod_q.hr} <= hr_to12(tod_q.hr);
                end else begin
                    tod_q.hr <= hr_to24(tod_q.pm, tod_q.hr);
                    tod_q.pm <= 1'b0;
                end
            end else if (tod_go) begin
                tod_q <= tod_nxt;
            end
            tchg_q <= tod_go;

            if (cal_wr_en) begin
                if (wr_cal_ok) cal_q <= wr_cal;
                cal_ok <= wr_cal_ok;
            end else if (cal_go) begin
                cal_q <= cal_nxt;
            end
            cchg_q <= cal_go;

            if (ctl_wr_en) ctl_q <= ctl_wr_data;
        end
    end

    assign time_word = {tchg_q, tod_q.pm, tod_q.hr, 1'b0, tod_q.mn, 1'b0, tod_q.sc, tod_q.hs};
    assign cal_word  = {cchg_q, 1'b0, cal_q.cent, cal_q.yr, 2'b00, cal_q.date, cal_q.mon, cal_q.wday};

endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tm_wr_en,
    input logic        cal_wr_en,
    input logic        hm_wr_en,
    input logic [31:0] time_word,
    input logic [31:0] cal_word,
    input logic [1:0]  ctl_q,
    input logic        hour_mode,
    input logic        time_ok,
    input logic        cal_ok
);

    // R5
    tod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[0] && !tm_wr_en && !hm_wr_en) |=> $stable(time_word[30:0]));

    // R5
    cal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[1] && !cal_wr_en) |=> $stable(cal_word[30:0]));

    // R9
    tok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(time_ok) |-> $past(tm_wr_en));

    // R10
    cok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_ok) |-> $past(cal_wr_en));

    // R2
    bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (time_word[3:0] <= 4'd9) && (time_word[7:4] <= 4'd9) && (time_word[14:12] <= 3'd5));

    // R12
    chg_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_word[31] |-> $past(time_word[31]));

    // R8
    wday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_word[2:0] != 3'd0);

    // R4
    hour24_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hour_mode |-> (!time_word[30] && (time_word[29:24] <= 6'h23)));

endmodule

bind bcd_rtc_core bcd_rtc_core_chk u_rtc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tm_wr_en  (tm_wr_en),
    .cal_wr_en (cal_wr_en),
    .hm_wr_en  (hm_wr_en),
    .time_word (time_word),
    .cal_word  (cal_word),
    .ctl_q     (ctl_q),
    .hour_mode (hour_mode),
    .time_ok   (time_ok),
    .cal_ok    (cal_ok)
);

// File: tb/tb_bcd_rtc_core.sv
`timescale 1ns/1ps
module tb_bcd_rtc_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        tm_wr_en = 1'b0, cal_wr_en = 1'b0, ctl_wr_en = 1'b0, hm_wr_en = 1'b0;
    logic [31:0] tm_wr_data = '0, cal_wr_data = '0;
    logic [1:0]  ctl_wr_data = '0;
    logic        hm_wr_data = 1'b0;
    logic [31:0] time_word, cal_word, tw_s, cw_s;
    logic [1:0]  ctl_q, ctl_s;
    logic        hour_mode, time_ok, cal_ok, hm_s, tok_s, cok_s;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] ref_t, ref_c;

    always #2 clk = ~clk;

    bcd_rtc_core #(.TICK_HZ(100)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tm_wr_en(tm_wr_en), .tm_wr_data(tm_wr_data),
        .cal_wr_en(cal_wr_en), .cal_wr_data(cal_wr_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .hm_wr_en(hm_wr_en), .hm_wr_data(hm_wr_data),
        .time_word(time_word), .cal_word(cal_word), .ctl_q(ctl_q),
        .hour_mode(hour_mode), .time_ok(time_ok), .cal_ok(cal_ok));

    bcd_rtc_core #(.TICK_HZ(1)) dut_s (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .tm_wr_en(tm_wr_en), .tm_wr_data(tm_wr_data),
        .cal_wr_en(cal_wr_en), .cal_wr_data(cal_wr_data),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .hm_wr_en(hm_wr_en), .hm_wr_data(hm_wr_data),
        .time_word(tw_s), .cal_word(cw_s), .ctl_q(ctl_s),
        .hour_mode(hm_s), .time_ok(tok_s), .cal_ok(cok_s));

    function automatic logic [7:0] b2(input int v);
        return 8'(((v / 10) % 10) * 16 + (v % 10));
    endfunction

    function automatic logic [31:0] mk_time(input int hs, input int s, input int m, input int h, input int pm);
        logic [7:0] bh, bm, bs;
        bh = b2(h); bm = b2(m); bs = b2(s);
        return {1'b0, 1'(pm), bh[5:0], 1'b0, bm[6:0], 1'b0, bs[6:0], b2(hs)};
    endfunction

    function automatic logic [31:0] mk_cal(input int wd, input int m, input int d, input int y);
        logic [7:0] bc, bm, bd;
        bc = b2(y / 100); bm = b2(m); bd = b2(d);
        return {2'b00, bc[5:0], b2(y % 100), 2'b00, bd[5:0], bm[4:0], 3'(wd)};
    endfunction

    function automatic int dim(input int m, input int y);
        bit leap;
        leap = (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
        if (m == 2) return leap ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_time(input logic [31:0] w);
        @(negedge clk) begin tm_wr_en = 1'b1; tm_wr_data = w; end
        @(negedge clk) tm_wr_en = 1'b0;
    endtask

    task automatic wr_cal(input logic [31:0] w);
        @(negedge clk) begin cal_wr_en = 1'b1; cal_wr_data = w; end
        @(negedge clk) cal_wr_en = 1'b0;
    endtask

    task automatic wr_ctl(input logic [1:0] c);
        @(negedge clk) begin ctl_wr_en = 1'b1; ctl_wr_data = c; end
        @(negedge clk) ctl_wr_en = 1'b0;
    endtask

    task automatic wr_hm(input logic m);
        @(negedge clk) begin hm_wr_en = 1'b1; hm_wr_data = m; end
        @(negedge clk) hm_wr_en = 1'b0;
    endtask

    // after return: time step visible; calendar step visible one negedge later
    task automatic step_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    // midnight through the last day of month m of year y
    task automatic roll_month(input int y, input int m);
        int d, wd, nd, nm, ny, nwd;
        d = dim(m, y); wd = (m % 7) + 1;
        wr_cal(mk_cal(wd, m, d + 1, y));
        chk("R10 date past month end rejected", {31'b0, cal_ok}, 32'd0);
        chk("R10 rejected calendar unchanged", cal_word, ref_c);
        wr_cal(mk_cal(wd, m, d, y));
        chk("R10 last day accepted", {31'b0, cal_ok}, 32'd1);
        wr_time(mk_time(99, 59, 59, 23, 0));
        step_tick();
        chk("R3 midnight wrap with change bit R12", time_word, 32'h8000_0000);
        @(negedge clk);
        nd = 1; nm = (m == 12) ? 1 : m + 1; ny = (m == 12) ? y + 1 : y;
        nwd = (wd == 7) ? 1 : wd + 1;
        chk("R6 R7 R8 calendar step", cal_word, mk_cal(nwd, nm, nd, ny) | 32'h8000_0000);
        chk("R12 time change bit cleared", time_word, 32'h0);
        @(negedge clk);
        ref_c = mk_cal(nwd, nm, nd, ny);
        chk("R12 calendar change bit cleared", cal_word, ref_c);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int yrs[6];
        yrs = '{1900, 1999, 2000, 2004, 2023, 2100};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset time", time_word, 32'h0);
        chk("R1 reset calendar", cal_word, mk_cal(1, 1, 1, 1900));
        chk("R1 reset stop bits", {30'b0, ctl_q}, 32'd3);
        chk("R1 reset mode and flags", {29'b0, hour_mode, time_ok, cal_ok}, 32'd0);

        step_tick();
        chk("R5 stopped time ignores tick", time_word, 32'h0);
        wr_ctl(2'b00);

        wr_time(32'h0);
        for (int k = 1; k <= 100; k++) begin
            step_tick();
            chk("R2 hundredths count", time_word[30:0], mk_time(k % 100, k / 100, 0, 0, 0));
        end
        chk("R2 one-hertz build adds seconds", {1'b0, tw_s[30:0]}, mk_time(0, 40, 1, 0, 0));

        ref_t = mk_time(0, 40, 1, 0, 0);
        wr_time(ref_t);
        for (int s = 0; s < 128; s++) begin
            logic [31:0] w;
            logic ok;
            w  = {17'b0, 7'(s), 8'h00};
            ok = (s / 16 <= 5) && (s % 16 <= 9);
            wr_time(w);
            if (ok) ref_t = w;
            chk("R9 seconds field check", {31'b0, time_ok}, {31'b0, ok});
            chk("R9 time word after write", time_word, ref_t);
        end
        for (int h = 0; h < 64; h++) begin
            logic [31:0] w;
            logic ok;
            w  = {2'b00, 6'(h), 24'h0};
            ok = (h % 16 <= 9) && (h <= 'h23);
            wr_time(w);
            if (ok) ref_t = w;
            chk("R9 24h hour field check", {31'b0, time_ok}, {31'b0, ok});
            chk("R9 time word after hour write", time_word, ref_t);
        end

        wr_time(mk_time(0, 0, 0, 13, 0));
        wr_hm(1'b1);
        chk("R4 switch to 12h converts 13h", time_word, mk_time(0, 0, 0, 1, 1));
        ref_t = time_word;
        for (int h = 0; h < 64; h++) begin
            logic [31:0] w;
            logic ok;
            w  = {2'b01, 6'(h), 24'h0};
            ok = (h % 16 <= 9) && (h != 0) && (h <= 'h12);
            wr_time(w);
            if (ok) ref_t = w;
            chk("R9 12h hour field check", {31'b0, time_ok}, {31'b0, ok});
        end

        ref_c = mk_cal(2, 3, 14, 2023);
        wr_cal(ref_c);
        wr_time(mk_time(99, 59, 59, 11, 1));
        step_tick();
        chk("R4 11 PM wraps to 12 AM", time_word[30:0], mk_time(0, 0, 0, 12, 0));
        @(negedge clk);
        chk("R4 midnight in 12h steps date", cal_word[30:0], mk_cal(3, 3, 15, 2023));
        ref_c = mk_cal(3, 3, 15, 2023);
        wr_time(mk_time(99, 59, 59, 11, 0));
        step_tick();
        chk("R4 11 AM goes to 12 PM", time_word[30:0], mk_time(0, 0, 0, 12, 1));
        @(negedge clk);
        chk("R4 noon leaves date", cal_word, ref_c);
        wr_time(mk_time(99, 59, 59, 12, 1));
        step_tick();
        chk("R4 12 PM goes to 1 PM", time_word[30:0], mk_time(0, 0, 0, 1, 1));
        wr_time(mk_time(0, 0, 0, 12, 0));
        wr_hm(1'b0);
        chk("R4 12 AM converts to 00h", time_word, mk_time(0, 0, 0, 0, 0));

        wr_ctl(2'b10);
        wr_time(mk_time(99, 59, 59, 23, 0));
        step_tick();
        @(negedge clk);
        chk("R5 time wraps with calendar stopped", time_word, 32'h0);
        chk("R5 stopped calendar unchanged", cal_word, ref_c);
        wr_ctl(2'b01);
        wr_time(mk_time(10, 0, 0, 5, 0));
        step_tick();
        chk("R5 stopped time holds", time_word, mk_time(10, 0, 0, 5, 0));
        wr_ctl(2'b00);

        foreach (yrs[i])
            for (int m = 1; m <= 12; m++)
                roll_month(yrs[i], m);

        wr_cal(mk_cal(1, 1, 1, 3000));
        chk("R10 century 30 rejected", {31'b0, cal_ok}, 32'd0);
        wr_cal(mk_cal(1, 12, 31, 1899));
        chk("R10 century 18 rejected", {31'b0, cal_ok}, 32'd0);
        wr_cal(mk_cal(1, 13, 1, 2000));
        chk("R10 month 13 rejected", {31'b0, cal_ok}, 32'd0);
        wr_cal(mk_cal(0, 1, 1, 2000));
        chk("R10 weekday 0 rejected", {31'b0, cal_ok}, 32'd0);

        ref_c = mk_cal(5, 12, 31, 2999);
        wr_cal(ref_c);
        wr_time(mk_time(99, 59, 59, 23, 0));
        step_tick();
        @(negedge clk);
        chk("R11 time held at limit", time_word, mk_time(99, 59, 59, 23, 0));
        chk("R11 calendar held at limit", cal_word, ref_c);
        step_tick();
        chk("R11 further tick ignored", time_word, mk_time(99, 59, 59, 23, 0));
        wr_time(32'h0);
        step_tick();
        chk("R11 valid write resumes counting", time_word, mk_time(1, 0, 0, 0, 0) | 32'h8000_0000);

        wr_time(mk_time(7, 8, 9, 10, 0) | 32'h8000_0000);
        chk("R12 written change bit ignored", time_word, mk_time(7, 8, 9, 10, 0));

        @(negedge clk) begin tm_wr_en = 1'b1; tm_wr_data = mk_time(50, 30, 20, 10, 0); tick = 1'b1; end
        @(negedge clk) begin tm_wr_en = 1'b0; tick = 1'b0; end
        chk("R13 write beats tick", time_word, mk_time(50, 30, 20, 10, 0));
        @(negedge clk);
        chk("R13 no late advance", time_word, mk_time(50, 30, 20, 10, 0));

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule